// File: doc/BRIEF.md
# APB GPIO Register Controller

This block is the register front end of a general purpose IO controller. It is an APB slave. It holds the configuration words that steer a row of IO pads: input enable, output value, output enable, pull enable and three drive-strength words. It also holds the interrupt enable and pending words used by a separate edge/level interrupt unit. The number of IOs is a parameter, 16 by default. All registers sit on 4-byte-aligned offsets inside a 256-byte window. Byte strobes select which lanes of a word a write updates.

Three override masks sit on top of the plain output value. A set mask forces pad bits high, a clear mask forces them low, and an invert mask flips the result. The combined value drives the pad output pins. The interrupt unit reports detected events on four per-bit pulse inputs (rise, fall, high, low). Each event latches a sticky pending bit, and software clears the bit by writing a one to it. Any offset in the window without a register ends its transfer with a slave error.

Top module: `gpio_apb_regs`

## Requirements
- R1: Every APB transfer completes with no wait states: `pready` is high in the access phase. A write takes effect at the clock edge that ends the access phase, and read data and `pslverr` are valid during the access phase.
- R2: Each stored word drives its output port directly. The offsets are: pad input enable 0x04 (`pad_ie`), output value 0x08, output enable 0x0C (`pad_oe`), pull enable 0x10 (`pad_pull`), drive0 0x14, drive1 0x44, drive2 0x48. The interrupt enables are rise 0x18, fall 0x20, high 0x28 and low 0x30.
- R3: After a synchronous active-low reset, every register reads zero and every pad and interrupt output is zero.
- R4: Bits at or above `IO_COUNT` ignore writes and always read as zero.
- R5: An access to an offset whose word index (offset / 4) is 19 or more, that is offset 0x4C to 0xFF, returns `pslverr` = 1 and changes no register. An access to a listed offset returns `pslverr` = 0.
- R6: On a write, byte lane k (bits 8k+7..8k) is updated only when `pstrb[k]` is 1. The other lanes keep their value.
- R7: The input value word at 0x00 is read-only and returns `in_val`. A write to it is ignored and completes without error.
- R8: `pad_out` = ((output value & ~clear) | set) ^ invert, bit by bit. Set is at 0x38, clear at 0x3C and invert at 0x40.
- R9: The pending words are rise 0x1C, fall 0x24, high 0x2C and low 0x34. A one on the matching event input sets the bit on the next edge, and the bit then stays set. Writing one clears the bit, and writing zero leaves it as it is. An event in the same cycle as a clear wins, so the bit stays set.
- R10: Reads have no side effects. Reading a pending word twice returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | synchronous active-low reset |
| psel | input | 1 | slave select |
| penable | input | 1 | access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | ADDR_W | byte offset in window |
| pwdata | input | 32 | write data |
| pstrb | input | 4 | write byte strobes |
| prdata | output | 32 | read data |
| pready | output | 1 | transfer ready |
| pslverr | output | 1 | slave error |
| in_val | input | IO_COUNT | synchronized pad input value |
| evt_rise | input | IO_COUNT | rising-edge event pulses |
| evt_fall | input | IO_COUNT | falling-edge event pulses |
| evt_high | input | IO_COUNT | high-level event pulses |
| evt_low | input | IO_COUNT | low-level event pulses |
| pad_ie | output | IO_COUNT | pad input enables |
| pad_out | output | IO_COUNT | final pad output value |
| pad_oe | output | IO_COUNT | pad output enables |
| pad_pull | output | IO_COUNT | pad pull enables |
| pad_drv0 | output | IO_COUNT | drive strength bit 0 |
| pad_drv1 | output | IO_COUNT | drive strength bit 1 |
| pad_drv2 | output | IO_COUNT | drive strength bit 2 |
| irq_rise_en | output | IO_COUNT | rise interrupt enables |
| irq_fall_en | output | IO_COUNT | fall interrupt enables |
| irq_high_en | output | IO_COUNT | high interrupt enables |
| irq_low_en | output | IO_COUNT | low interrupt enables |
| irq_rise_pend | output | IO_COUNT | rise pending bits |
| irq_fall_pend | output | IO_COUNT | fall pending bits |
| irq_high_pend | output | IO_COUNT | high pending bits |
| irq_low_pend | output | IO_COUNT | low pending bits |

## Verification
Read data and `pslverr` are combinational, so they are due during the access phase. The bench samples them 1 ns after it raises `penable` on a falling edge. A write or an event pulse lands on the next rising edge. The bench therefore reads register outputs such as `pad_oe`, `pad_out` and the pending ports at the falling edge after that, one full edge after the commit. `pad_out` has no register of its own, so it is checked at the same falling edge as the words that feed it.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
   localparam int NUM_REGS      = 19;
   localparam int IDX_IN        = 0;
   localparam int IDX_IE        = 1;
   localparam int IDX_OVAL      = 2;
   localparam int IDX_OE        = 3;
   localparam int IDX_PULL      = 4;
   localparam int IDX_DRV0      = 5;
   localparam int IDX_RISE_EN   = 6;
   localparam int IDX_RISE_PEND = 7;
   localparam int IDX_FALL_EN   = 8;
   localparam int IDX_FALL_PEND = 9;
   localparam int IDX_HIGH_EN   = 10;
   localparam int IDX_HIGH_PEND = 11;
   localparam int IDX_LOW_EN    = 12;
   localparam int IDX_LOW_PEND  = 13;
   localparam int IDX_SET       = 14;
   localparam int IDX_CLR       = 15;
   localparam int IDX_INV       = 16;
   localparam int IDX_DRV1      = 17;
   localparam int IDX_DRV2      = 18;

   // pending words sit on odd indices 7..13
   function automatic bit is_pend(input int idx);
      return (idx >= IDX_RISE_PEND) && (idx <= IDX_LOW_PEND) && (idx % 2 == 1);
   endfunction

   // expand 4 byte strobes into a 32-bit bit mask
   function automatic logic [31:0] lane_mask(input logic [3:0] strb);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{strb[k]}};
      return m;
   endfunction
endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode #(
   parameter int ADDR_W = 8,
   parameter int NREG   = 19,
   localparam int WORD_W = ADDR_W - 2,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic [ADDR_W-1:0] paddr,
   input  logic              access,
   input  logic              pwrite,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output logic [NREG-1:0]   wr_sel
);
   localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NREG);

   if (WORD_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too small for register map");
   end

   logic [WORD_W-1:0] word;
   assign word = paddr[ADDR_W-1:2];
   assign hit  = (word < LIMIT);
   assign idx  = word[IDX_W-1:0];

   for (genvar r = 0; r < NREG; r++) begin : g_sel
      assign wr_sel[r] = access & pwrite & hit & (idx == IDX_W'(r));
   end
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= (q & ~wmask) | (wdata & wmask);
   end
endmodule

// File: rtl/gpio_pend_reg.sv
module gpio_pend_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] evt,
   output logic [W-1:0] q
);
   logic [W-1:0] clr;
   assign clr = we ? (wdata & wmask) : '0;

   // an event in the clearing cycle survives
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | evt;
   end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int W = 16
) (
   input  logic [W-1:0] oval,
   input  logic [W-1:0] force_lo,
   input  logic [W-1:0] force_hi,
   input  logic [W-1:0] invert,
   output logic [W-1:0] pad
);
   assign pad = ((oval & ~force_lo) | force_hi) ^ invert;
endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
   import gpio_regs_pkg::*;
#(
   parameter int IO_COUNT = 16,
   parameter int ADDR_W   = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                pclk,
   input  logic                presetn,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [31:0]         pwdata,
   input  logic [3:0]          pstrb,
   output logic [31:0]         prdata,
   output logic                pready,
   output logic                pslverr,
   input  logic [IO_COUNT-1:0] in_val,
   input  logic [IO_COUNT-1:0] evt_rise,
   input  logic [IO_COUNT-1:0] evt_fall,
   input  logic [IO_COUNT-1:0] evt_high,
   input  logic [IO_COUNT-1:0] evt_low,
   output logic [IO_COUNT-1:0] pad_ie,
   output logic [IO_COUNT-1:0] pad_out,
   output logic [IO_COUNT-1:0] pad_oe,
   output logic [IO_COUNT-1:0] pad_pull,
   output logic [IO_COUNT-1:0] pad_drv0,
   output logic [IO_COUNT-1:0] pad_drv1,
   output logic [IO_COUNT-1:0] pad_drv2,
   output logic [IO_COUNT-1:0] irq_rise_en,
   output logic [IO_COUNT-1:0] irq_fall_en,
   output logic [IO_COUNT-1:0] irq_high_en,
   output logic [IO_COUNT-1:0] irq_low_en,
   output logic [IO_COUNT-1:0] irq_rise_pend,
   output logic [IO_COUNT-1:0] irq_fall_pend,
   output logic [IO_COUNT-1:0] irq_high_pend,
   output logic [IO_COUNT-1:0] irq_low_pend
);
   if (IO_COUNT < 2 || IO_COUNT > 31) begin : g_bad_io
      $error("IO_COUNT must lie in 2..31");
   end
   if (ADDR_W != 8) begin : g_bad_win
      $error("register window is 256 bytes, ADDR_W must be 8");
   end

   logic                access;
   logic                hit;
   logic [IDX_W-1:0]    idx;
   logic [NUM_REGS-1:0] wr_sel;
   logic [31:0]         mask32;
   logic [IO_COUNT-1:0] wmask;
   logic [IO_COUNT-1:0] wdata;
   logic [IO_COUNT-1:0] regv [NUM_REGS];
   logic [IO_COUNT-1:0] evt_vec [4];

   assign access = psel & penable;
   assign mask32 = lane_mask(pstrb);
   assign wmask  = mask32[IO_COUNT-1:0];
   assign wdata  = pwdata[IO_COUNT-1:0];

   assign evt_vec[0] = evt_rise;
   assign evt_vec[1] = evt_fall;
   assign evt_vec[2] = evt_high;
   assign evt_vec[3] = evt_low;

   gpio_apb_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
      .paddr  (paddr),
      .access (access),
      .pwrite (pwrite),
      .hit    (hit),
      .idx    (idx),
      .wr_sel (wr_sel)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (r == IDX_IN) begin : g_ro
         assign regv[r] = in_val;
      end else if (is_pend(r)) begin : g_w1c
         gpio_pend_reg #(.W(IO_COUNT)) u_pend (
            .clk   (pclk),
            .rst_n (presetn),
            .we    (wr_sel[r]),
            .wmask (wmask),
            .wdata (wdata),
            .evt   (evt_vec[(r - IDX_RISE_PEND) / 2]),
            .q     (regv[r])
         );
      end else begin : g_rw
         gpio_cfg_reg #(.W(IO_COUNT)) u_cfg (
            .clk   (pclk),
            .rst_n (presetn),
            .we    (wr_sel[r]),
            .wmask (wmask),
            .wdata (wdata),
            .q     (regv[r])
         );
      end
   end

   logic [IO_COUNT-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      for (int r = 0; r < NUM_REGS; r++)
         if (hit && idx == IDX_W'(r)) rd_word = regv[r];
   end

   assign prdata  = {{(32-IO_COUNT){1'b0}}, rd_word};
   assign pready  = 1'b1;
   assign pslverr = access & ~hit;

   gpio_pad_drive #(.W(IO_COUNT)) u_drive (
      .oval     (regv[IDX_OVAL]),
      .force_lo (regv[IDX_CLR]),
      .force_hi (regv[IDX_SET]),
      .invert   (regv[IDX_INV]),
      .pad      (pad_out)
   );

   assign pad_ie        = regv[IDX_IE];
   assign pad_oe        = regv[IDX_OE];
   assign pad_pull      = regv[IDX_PULL];
   assign pad_drv0      = regv[IDX_DRV0];
   assign pad_drv1      = regv[IDX_DRV1];
   assign pad_drv2      = regv[IDX_DRV2];
   assign irq_rise_en   = regv[IDX_RISE_EN];
   assign irq_fall_en   = regv[IDX_FALL_EN];
   assign irq_high_en   = regv[IDX_HIGH_EN];
   assign irq_low_en    = regv[IDX_LOW_EN];
   assign irq_rise_pend = regv[IDX_RISE_PEND];
   assign irq_fall_pend = regv[IDX_FALL_PEND];
   assign irq_high_pend = regv[IDX_HIGH_PEND];
   assign irq_low_pend  = regv[IDX_LOW_PEND];
endmodule

// File: rtl/gpio_apb_regs_chk.sv
module gpio_apb_regs_chk #(
   parameter int IO_COUNT = 16,
   parameter int ADDR_W   = 8
) (
   input logic                pclk,
   input logic                presetn,
   input logic                psel,
   input logic                penable,
   input logic                pwrite,
   input logic [ADDR_W-1:0]   paddr,
   input logic [31:0]         pwdata,
   input logic [3:0]          pstrb,
   input logic [31:0]         prdata,
   input logic                pslverr,
   input logic [IO_COUNT-1:0] evt_rise,
   input logic [IO_COUNT-1:0] pad_ie,
   input logic [IO_COUNT-1:0] pad_out,
   input logic [IO_COUNT-1:0] pad_oe,
   input logic [IO_COUNT-1:0] irq_rise_pend
);
   logic acc;
   logic oe_full_wr;
   logic rise_pend_wr;
   assign acc          = psel && penable;
   assign oe_full_wr   = acc && pwrite && (paddr == ADDR_W'(8'h0C)) && (pstrb == 4'hF);
   assign rise_pend_wr = acc && pwrite && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(7));

   assert_write_commit_R1: assert property (@(posedge pclk) disable iff (!presetn)
      oe_full_wr |=> (pad_oe == $past(pwdata[IO_COUNT-1:0])));

   assert_unmapped_err_R5: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && (paddr[ADDR_W-1:2] >= (ADDR_W-2)'(19))) |-> pslverr);

   assert_err_no_update_R5: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && pslverr) |=> ($stable(pad_oe) && $stable(pad_ie) && $stable(pad_out)));

   assert_upper_zero_R4: assert property (@(posedge pclk) disable iff (!presetn)
      ((prdata >> IO_COUNT) == 32'd0));

   assert_pend_sticky_R9: assert property (@(posedge pclk) disable iff (!presetn)
      !rise_pend_wr |=> ((irq_rise_pend & $past(irq_rise_pend)) == $past(irq_rise_pend)));

   assert_evt_sets_R9: assert property (@(posedge pclk) disable iff (!presetn)
      (|evt_rise) |=> ((irq_rise_pend & $past(evt_rise)) == $past(evt_rise)));
endmodule

bind gpio_apb_regs gpio_apb_regs_chk #(.IO_COUNT(IO_COUNT), .ADDR_W(ADDR_W)) u_chk (
   .pclk          (pclk),
   .presetn       (presetn),
   .psel          (psel),
   .penable       (penable),
   .pwrite        (pwrite),
   .paddr         (paddr),
   .pwdata        (pwdata),
   .pstrb         (pstrb),
   .prdata        (prdata),
   .pslverr       (pslverr),
   .evt_rise      (evt_rise),
   .pad_ie        (pad_ie),
   .pad_out       (pad_out),
   .pad_oe        (pad_oe),
   .irq_rise_pend (irq_rise_pend)
);

// File: tb/gpio_apb_regs_tb.sv
module gpio_apb_regs_tb;
   localparam int IO = 16;
   localparam logic [31:0] VMASK = 32'h0000_FFFF;

   logic        clk = 0;
   logic        rstn = 0;
   logic        psel = 0, penable = 0, pwrite = 0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [3:0]  pstrb = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [IO-1:0] in_val = '0, evt_rise = '0, evt_fall = '0, evt_high = '0, evt_low = '0;
   logic [IO-1:0] pad_ie, pad_out, pad_oe, pad_pull, pad_drv0, pad_drv1, pad_drv2;
   logic [IO-1:0] irq_rise_en, irq_fall_en, irq_high_en, irq_low_en;
   logic [IO-1:0] irq_rise_pend, irq_fall_pend, irq_high_pend, irq_low_pend;
   logic [IO-1:0] acc_evt_rise = '0;

   int total = 0, bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_apb_regs #(.IO_COUNT(IO), .ADDR_W(8)) u_dut (
      .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .in_val(in_val), .evt_rise(evt_rise), .evt_fall(evt_fall),
      .evt_high(evt_high), .evt_low(evt_low), .pad_ie(pad_ie), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_drv0(pad_drv0), .pad_drv1(pad_drv1),
      .pad_drv2(pad_drv2), .irq_rise_en(irq_rise_en), .irq_fall_en(irq_fall_en),
      .irq_high_en(irq_high_en), .irq_low_en(irq_low_en), .irq_rise_pend(irq_rise_pend),
      .irq_fall_pend(irq_fall_pend), .irq_high_pend(irq_high_pend), .irq_low_pend(irq_low_pend)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   logic [31:0] rd;
   logic        er, rdy;

   task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] s);
      @(negedge clk);
      psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
      @(negedge clk);
      penable = 1; evt_rise = acc_evt_rise;
      #1; rd = prdata; er = pslverr; rdy = pready;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0; evt_rise = '0;
   endtask

   task automatic wr32(input logic [7:0] a, input logic [31:0] d);
      xfer(1'b1, a, d, 4'hF);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      xfer(1'b0, a, 32'h0, 4'h0);
      chk(req, rd, exp);
   endtask

   function automatic bit is_ro_or_pend(input int i);
      return (i == 0) || (i == 7) || (i == 9) || (i == 11) || (i == 13);
   endfunction

   function automatic logic [31:0] pat(input int i);
      return (32'hA5C3_0000 | (32'h0000_1357 * (i + 1))) & VMASK;
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rstn = 1;
      @(negedge clk);

      // R3: reset state
      chk("R3 pad_oe", {16'h0, pad_oe}, 32'h0);
      chk("R3 pad_out", {16'h0, pad_out}, 32'h0);
      for (int i = 0; i < 19; i++) rd_chk("R3 reset read", 8'(i * 4), 32'h0);

      // R1: zero wait, R5 mapped no error
      xfer(1'b0, 8'h08, 32'h0, 4'h0);
      chk("R1 pready", {31'h0, rdy}, 32'h1);
      chk("R5 mapped err", {31'h0, er}, 32'h0);

      // R4: upper bits ignore writes, full sweep of read-write words
      for (int i = 0; i < 19; i++) begin
         if (!is_ro_or_pend(i)) begin
            wr32(8'(i * 4), 32'hFFFF_FFFF);
            rd_chk("R4 upper zero", 8'(i * 4), VMASK);
            wr32(8'(i * 4), pat(i) | 32'hFFFF_0000);
            rd_chk("R2 readback", 8'(i * 4), pat(i));
         end
      end

      // R2: outputs follow stored words
      chk("R2 pad_ie",   {16'h0, pad_ie},   pat(1));
      chk("R2 pad_oe",   {16'h0, pad_oe},   pat(3));
      chk("R2 pad_pull", {16'h0, pad_pull}, pat(4));
      chk("R2 pad_drv0", {16'h0, pad_drv0}, pat(5));
      chk("R2 pad_drv1", {16'h0, pad_drv1}, pat(17));
      chk("R2 pad_drv2", {16'h0, pad_drv2}, pat(18));
      chk("R2 rise_en",  {16'h0, irq_rise_en}, pat(6));
      chk("R2 fall_en",  {16'h0, irq_fall_en}, pat(8));
      chk("R2 high_en",  {16'h0, irq_high_en}, pat(10));
      chk("R2 low_en",   {16'h0, irq_low_en},  pat(12));

      // R6: byte lanes
      wr32(8'h10, 32'h0000_FFFF);
      xfer(1'b1, 8'h10, 32'h0000_1234, 4'b0001);
      rd_chk("R6 lane0", 8'h10, 32'h0000_FF34);
      xfer(1'b1, 8'h10, 32'h0000_AB00, 4'b0010);
      rd_chk("R6 lane1", 8'h10, 32'h0000_AB34);
      xfer(1'b1, 8'h10, 32'hFFFF_0000, 4'b1100);
      rd_chk("R6 upper lanes R4", 8'h10, 32'h0000_AB34);
      xfer(1'b1, 8'h10, 32'h0000_5566, 4'b0000);
      rd_chk("R6 no strobe", 8'h10, 32'h0000_AB34);

      // R5: unmapped sweep; writes change nothing
      for (int a = 8'h4C; a < 256; a += 4) begin
         xfer(1'b1, 8'(a), 32'h0000_0000, 4'hF);
         chk("R5 unmapped err", {31'h0, er}, 32'h1);
      end
      chk("R5 oe untouched", {16'h0, pad_oe}, pat(3));
      rd_chk("R5 ie untouched", 8'h04, pat(1));

      // R7: read-only input word
      in_val = 16'hC0DE;
      rd_chk("R7 input read", 8'h00, 32'h0000_C0DE);
      wr32(8'h00, 32'h0000_1111);
      chk("R7 write no err", {31'h0, er}, 32'h0);
      rd_chk("R7 write ignored", 8'h00, 32'h0000_C0DE);
      in_val = 16'h0F0F;
      rd_chk("R7 input follows", 8'h00, 32'h0000_0F0F);

      // R8: all 16 combinations of (oval, clr, set, inv), one per bit
      wr32(8'h08, 32'h0000_AAAA);
      wr32(8'h3C, 32'h0000_CCCC);
      wr32(8'h38, 32'h0000_F0F0);
      wr32(8'h40, 32'h0000_FF00);
      begin
         logic [15:0] e;
         for (int b = 0; b < 16; b++) begin
            int o, c, s, x;
            o = b & 1; c = (b >> 1) & 1; s = (b >> 2) & 1; x = (b >> 3) & 1;
            e[b] = 1'(((o & (1 - c)) | s) ^ x);
         end
         chk("R8 override combos", {16'h0, pad_out}, {16'h0, e});
      end
      wr32(8'h40, 32'h0);
      wr32(8'h38, 32'h0);
      wr32(8'h3C, 32'h0);
      chk("R8 plain value", {16'h0, pad_out}, 32'h0000_AAAA);

      // R9 / R10: pending words
      @(negedge clk); evt_rise = 16'h0008; @(negedge clk); evt_rise = '0;
      chk("R9 rise set port", {16'h0, irq_rise_pend}, 32'h0000_0008);
      rd_chk("R9 rise read", 8'h1C, 32'h0000_0008);
      rd_chk("R10 reread", 8'h1C, 32'h0000_0008);
      wr32(8'h1C, 32'h0);
      rd_chk("R9 write zero keeps", 8'h1C, 32'h0000_0008);
      wr32(8'h1C, 32'h0000_0008);
      rd_chk("R9 w1c clears", 8'h1C, 32'h0);
      @(negedge clk); evt_fall = 16'h8001; evt_high = 16'h0100; evt_low = 16'h0040;
      @(negedge clk); evt_fall = '0; evt_high = '0; evt_low = '0;
      rd_chk("R9 fall", 8'h24, 32'h0000_8001);
      rd_chk("R9 high", 8'h2C, 32'h0000_0100);
      rd_chk("R9 low",  8'h34, 32'h0000_0040);
      xfer(1'b1, 8'h24, 32'h0000_0001, 4'b0001);
      rd_chk("R9 fall lane clear", 8'h24, 32'h0000_8000);
      @(negedge clk); evt_rise = 16'h0010; @(negedge clk); evt_rise = '0;
      acc_evt_rise = 16'h0020;
      wr32(8'h1C, 32'h0000_0030);
      acc_evt_rise = '0;
      chk("R9 set beats clear", {16'h0, irq_rise_pend}, 32'h0000_0020);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule